// File: doc/BRIEF.md
# Secure Byte-Wide Memory Decoder

This block sits between a processor's access path and a private byte-wide SRAM bus. Each request carries a 16-bit logical address and an access kind (program fetch, data read or data write). The block works out a 17-bit physical address: program space is the lower 64K and data space the upper 64K. It then drives the SRAM address lines, the active-low chip enables, four active-low peripheral enables and an active-low write strobe. A size-select input chooses between four 32K SRAMs, one per chip enable, and a single 128K SRAM. In 128K mode two chip-enable pins carry the high address bits instead of acting as enables.

A peripheral-select input sends data accesses to four 16K peripheral windows instead of SRAM. A boundary input marks the low part of physical SRAM as program memory, and writes there are refused. A range input states how many 32K SRAMs are fitted. An access outside that range is not decoded; the block raises a one-cycle flag so the access can be taken by the external bus instead. A power-fail reset input and a battery-backup input force the outputs inactive.

Every access runs for a fixed window of registered enables, and a new request is accepted only when the block is idle.

Top module: `bwdec_top`

## Requirements
- R1: After reset, and whenever no access is in progress, ce_n, pe_n and rw_n are all high and busy and exp_bus are low.
- R2: In 32K mode (size_32k=1), with physical address P = {kind!=00, req_addr}, ce_n[P[16:15]] is the only low chip enable and ba = P[14:0]. Kind encoding: 00 program fetch, 01 and 11 data read, 10 data write.
- R3: In 128K mode (size_32k=0), ce_n[0] is low, ce_n[1] carries P[16], ce_n[2] carries P[15], ce_n[3] is held high, and ba = P[14:0]. Every address is in range.
- R4: In 32K mode an SRAM access whose block P[16:15] is greater than rng_blk starts no access: exp_bus is high for exactly the one cycle after the accepting edge, and busy and every enable stay inactive.
- R5: With periph_sel=1, a data access drives pe_n[req_addr[15:14]] low, keeps all ce_n high and sets ba = {0, req_addr[13:0]}. Program fetches still go to SRAM.
- R6: An SRAM data write whose P[16:12] is below prog_bound never drives rw_n low, yet runs its full write window. Peripheral writes are not subject to this check.
- R7: Counting the cycle after the accepting edge as cycle 0, reads and fetches hold their enables for cycles 0 to 3, and writes hold them for cycles 0 to 7. A permitted write holds rw_n low in cycles 1 to 6.
- R8: busy is high for the whole window. A request made while busy is ignored, and the outputs of the access in progress do not change.
- R9: While pfail is high, every ce_n, every pe_n and rw_n are high at once. An access in progress is dropped at the next edge, and requests are ignored.
- R10: While batt is high, all ce_n and pe_n[1:0] are forced high. pe_n[3:2] are not affected.
- R11: At most one peripheral enable is low at any time, and in 32K mode at most one chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, sampled when idle |
| req_kind | input | 2 | 00 fetch, 01/11 data read, 10 data write |
| req_addr | input | 16 | Logical address |
| size_32k | input | 1 | 1: four 32K SRAMs, 0: one 128K SRAM |
| periph_sel | input | 1 | Route data space to peripheral windows |
| rng_blk | input | 2 | Highest populated 32K block in 32K mode |
| prog_bound | input | 5 | Program/data boundary in 4K physical units |
| pfail | input | 1 | Power-fail reset, active high |
| batt | input | 1 | Battery-backup mode, active high |
| ba | output | 15 | SRAM / peripheral address |
| ce_n | output | 4 | Chip enables (high address bits in 128K mode) |
| pe_n | output | 4 | Peripheral enables, active low |
| rw_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Access window in progress |
| exp_bus | output | 1 | One-cycle flag for an out-of-range access |

## Verification
The bench sweeps both sides of each decode boundary: 7FFFh/8000h for the fitted range, the two addresses on either side of the program boundary, and the edges of the 16K peripheral windows. A decoder that is off by one there would enable the wrong SRAM, or let a write through into program memory. In 128K mode it checks the ce_n pattern bit by bit, because swapping the two reused address pins would fold data space onto program space. It also checks the exact cycle where the write strobe begins and ends, which catches a strobe that leaks outside the enable window. Further checks raise a request during a busy window, drop power mid-write, and show that battery mode leaves the two upper peripheral enables alone, since a design that froze, kept a strobe low or masked every enable would then fail.

// File: rtl/bwdec_pkg.sv
package bwdec_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'b00,
      ACC_RD    = 2'b01,
      ACC_WR    = 2'b10,
      ACC_RD2   = 2'b11
   } acc_kind_e;

   localparam int DEF_LA_W   = 16;
   localparam int DEF_BA_W   = 15;
   localparam int DEF_N_CE   = 4;
   localparam int DEF_N_PE   = 4;
   localparam int DEF_EN_CYC = 4;
   localparam int DEF_WR_CYC = 6;
   localparam int DEF_BND_W  = 5;
   localparam logic [3:0] DEF_PE_BATT = 4'b0011;

endpackage

// File: rtl/bwdec_map.sv
module bwdec_map
   import bwdec_pkg::*;
#(
   parameter int LA_W  = DEF_LA_W,
   parameter int BA_W  = DEF_BA_W,
   parameter int N_CE  = DEF_N_CE,
   parameter int N_PE  = DEF_N_PE,
   parameter int BND_W = DEF_BND_W,
   localparam int PA_W  = LA_W + 1,
   localparam int BLK_W = PA_W - BA_W,
   localparam int PE_W  = $clog2(N_PE),
   localparam int WIN_W = LA_W - PE_W
) (
   input  logic [LA_W-1:0]  addr,
   input  acc_kind_e        kind,
   input  logic             size_32k,
   input  logic             periph_sel,
   input  logic [BLK_W-1:0] rng_blk,
   input  logic [BND_W-1:0] prog_bound,
   output logic [BA_W-1:0]  ba,
   output logic [N_CE-1:0]  ce_sel_n,
   output logic [N_PE-1:0]  pe_sel_n,
   output logic             wr_ok,
   output logic             out_rng,
   output logic             is_wr
);

   logic             is_data;
   logic             peri;
   logic             prog_hit;
   logic [PA_W-1:0]  phys;
   logic [BLK_W-1:0] blk;
   logic [N_CE-1:0]  ce_32k;
   logic [N_CE-1:0]  ce_wide;

   assign is_data  = (kind != ACC_FETCH);
   assign is_wr    = (kind == ACC_WR);
   assign phys     = {is_data, addr};
   assign blk      = phys[PA_W-1 -: BLK_W];
   assign peri     = periph_sel & is_data;
   assign prog_hit = phys[PA_W-1 -: BND_W] < prog_bound;

   // one enable per 32K block
   for (genvar i = 0; i < N_CE; i++) begin : g_ce32
      assign ce_32k[i] = (blk != BLK_W'(i));
   end

   // 128K mode: enables 1 and 2 become address bits 16 and 15
   assign ce_wide = {1'b1, phys[PA_W-2], phys[PA_W-1], 1'b0};

   // peripheral windows on the top logical address bits
   for (genvar j = 0; j < N_PE; j++) begin : g_pe
      assign pe_sel_n[j] = !(peri && (addr[LA_W-1 -: PE_W] == PE_W'(j)));
   end

   assign out_rng = !peri && size_32k && (blk > rng_blk);

   always_comb begin
      if (peri) begin
         ce_sel_n = '1;
         ba       = BA_W'(addr[WIN_W-1:0]);
      end else begin
         ba = phys[BA_W-1:0];
         if (size_32k) ce_sel_n = out_rng ? '1 : ce_32k;
         else          ce_sel_n = ce_wide;
      end
   end

   assign wr_ok = is_wr && (peri || !prog_hit);

endmodule

// File: rtl/bwdec_seq.sv
module bwdec_seq #(
   parameter int BA_W   = 15,
   parameter int N_CE   = 4,
   parameter int N_PE   = 4,
   parameter int EN_CYC = 4,
   parameter int WR_CYC = 6,
   localparam int WR_WIN  = WR_CYC + 2,
   localparam int MAX_WIN = (WR_WIN > EN_CYC) ? WR_WIN : EN_CYC,
   localparam int CNT_W   = $clog2(MAX_WIN + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pfail,
   input  logic            req_valid,
   input  logic            size_32k,
   input  logic [BA_W-1:0] dec_ba,
   input  logic [N_CE-1:0] dec_ce_n,
   input  logic [N_PE-1:0] dec_pe_n,
   input  logic            dec_wr_ok,
   input  logic            dec_out_rng,
   input  logic            dec_is_wr,
   output logic [BA_W-1:0] ba_q,
   output logic [N_CE-1:0] ce_q,
   output logic [N_PE-1:0] pe_q,
   output logic            rw_q,
   output logic            active,
   output logic            exp_q
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             wr_q;
   logic             sz_q;
   logic             start;

   assign start   = req_valid && !active && !pfail && !dec_out_rng;
   assign cnt_nxt = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
         last_q <= '0;
         ba_q   <= '0;
         ce_q   <= '1;
         pe_q   <= '1;
         rw_q   <= 1'b1;
         wr_q   <= 1'b0;
         sz_q   <= 1'b1;
         exp_q  <= 1'b0;
      end else if (pfail) begin
         active <= 1'b0;
         ce_q   <= '1;
         pe_q   <= '1;
         rw_q   <= 1'b1;
         exp_q  <= 1'b0;
      end else if (!active) begin
         exp_q <= req_valid && dec_out_rng;
         if (start) begin
            active <= 1'b1;
            cnt_q  <= '0;
            last_q <= dec_is_wr ? CNT_W'(WR_WIN - 1) : CNT_W'(EN_CYC - 1);
            ba_q   <= dec_ba;
            ce_q   <= dec_ce_n;
            pe_q   <= dec_pe_n;
            wr_q   <= dec_wr_ok;
            sz_q   <= size_32k;
            rw_q   <= 1'b1;
         end
      end else begin
         exp_q <= 1'b0;
         if (cnt_q == last_q) begin
            active <= 1'b0;
            ce_q   <= '1;
            pe_q   <= '1;
            rw_q   <= 1'b1;
         end else begin
            cnt_q <= cnt_nxt;
            rw_q  <= !(wr_q && (cnt_nxt <= CNT_W'(WR_CYC)));
         end
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (&ce_q && &pe_q && rw_q));                          // R1
   AST_EXP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |-> (!active && &ce_q));                                   // R4
   AST_PE_EXCLUDES_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !(&pe_q)) |-> &ce_q);                                 // R5
   AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !wr_q) |-> rw_q);                                     // R6
   AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_q |-> active);                                               // R7
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (cnt_q != last_q) && !pfail) |=>
         ($stable(ce_q) && $stable(pe_q) && $stable(ba_q)));           // R8
   AST_PFAIL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      pfail |=> (!active && rw_q));                                    // R9
   AST_ONE_PE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~pe_q));                                                // R11
   AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && sz_q) |-> $onehot0(~ce_q));                           // R11

endmodule

// File: rtl/bwdec_top.sv
module bwdec_top
   import bwdec_pkg::*;
#(
   parameter int LA_W   = DEF_LA_W,
   parameter int BA_W   = DEF_BA_W,
   parameter int N_CE   = DEF_N_CE,
   parameter int N_PE   = DEF_N_PE,
   parameter int EN_CYC = DEF_EN_CYC,
   parameter int WR_CYC = DEF_WR_CYC,
   parameter int BND_W  = DEF_BND_W,
   parameter logic [N_PE-1:0] PE_BATT = DEF_PE_BATT,
   localparam int BLK_W = LA_W + 1 - BA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [LA_W-1:0]  req_addr,
   input  logic             size_32k,
   input  logic             periph_sel,
   input  logic [BLK_W-1:0] rng_blk,
   input  logic [BND_W-1:0] prog_bound,
   input  logic             pfail,
   input  logic             batt,
   output logic [BA_W-1:0]  ba,
   output logic [N_CE-1:0]  ce_n,
   output logic [N_PE-1:0]  pe_n,
   output logic             rw_n,
   output logic             busy,
   output logic             exp_bus
);

   // elaboration-time parameter checks
   if (N_CE != (1 << BLK_W)) begin : g_bad_nce
      $error("bwdec_top: N_CE must equal the number of 32K blocks");
   end
   if (N_CE != 4) begin : g_bad_wide
      $error("bwdec_top: the 128K pin reuse needs exactly four chip enables");
   end
   if (N_PE != (1 << $clog2(N_PE)) || N_PE < 2) begin : g_bad_npe
      $error("bwdec_top: N_PE must be a power of two of at least 2");
   end
   if (BND_W > LA_W + 1) begin : g_bad_bnd
      $error("bwdec_top: boundary wider than the physical address");
   end
   if (EN_CYC < 1 || WR_CYC < 1) begin : g_bad_cyc
      $error("bwdec_top: window lengths must be positive");
   end

   logic [BA_W-1:0] d_ba;
   logic [N_CE-1:0] d_ce_n;
   logic [N_PE-1:0] d_pe_n;
   logic            d_wr_ok;
   logic            d_out_rng;
   logic            d_is_wr;
   logic [N_CE-1:0] ce_q;
   logic [N_PE-1:0] pe_q;
   logic            rw_q;

   bwdec_map #(
      .LA_W (LA_W), .BA_W (BA_W), .N_CE (N_CE), .N_PE (N_PE), .BND_W (BND_W)
   ) map_i (
      .addr       (req_addr),
      .kind       (acc_kind_e'(req_kind)),
      .size_32k   (size_32k),
      .periph_sel (periph_sel),
      .rng_blk    (rng_blk),
      .prog_bound (prog_bound),
      .ba         (d_ba),
      .ce_sel_n   (d_ce_n),
      .pe_sel_n   (d_pe_n),
      .wr_ok      (d_wr_ok),
      .out_rng    (d_out_rng),
      .is_wr      (d_is_wr)
   );

   bwdec_seq #(
      .BA_W (BA_W), .N_CE (N_CE), .N_PE (N_PE), .EN_CYC (EN_CYC), .WR_CYC (WR_CYC)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pfail       (pfail),
      .req_valid   (req_valid),
      .size_32k    (size_32k),
      .dec_ba      (d_ba),
      .dec_ce_n    (d_ce_n),
      .dec_pe_n    (d_pe_n),
      .dec_wr_ok   (d_wr_ok),
      .dec_out_rng (d_out_rng),
      .dec_is_wr   (d_is_wr),
      .ba_q        (ba),
      .ce_q        (ce_q),
      .pe_q        (pe_q),
      .rw_q        (rw_q),
      .active      (busy),
      .exp_q       (exp_bus)
   );

   // chip enables are all battery-backed
   for (genvar i = 0; i < N_CE; i++) begin : g_ce_out
      assign ce_n[i] = ce_q[i] | pfail | batt;
   end

   // peripheral enables: battery forcing only where PE_BATT marks it
   for (genvar j = 0; j < N_PE; j++) begin : g_pe_out
      if (PE_BATT[j]) begin : g_bk
         assign pe_n[j] = pe_q[j] | pfail | batt;
      end else begin : g_nb
         assign pe_n[j] = pe_q[j] | pfail;
      end
   end

   assign rw_n = rw_q | pfail;

endmodule

// File: tb/bwdec_top_tb_top.sv
module bwdec_top_tb_top;

   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [1:0]  req_kind;
   logic [15:0] req_addr;
   logic        size_32k;
   logic        periph_sel;
   logic [1:0]  rng_blk;
   logic [4:0]  prog_bound;
   logic        pfail;
   logic        batt;
   logic [14:0] ba;
   logic [3:0]  ce_n;
   logic [3:0]  pe_n;
   logic        rw_n;
   logic        busy;
   logic        exp_bus;

   always #(CLK_PER/2) clk = ~clk;

   bwdec_top dut_i (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
      .req_addr (req_addr), .size_32k (size_32k), .periph_sel (periph_sel),
      .rng_blk (rng_blk), .prog_bound (prog_bound), .pfail (pfail), .batt (batt),
      .ba (ba), .ce_n (ce_n), .pe_n (pe_n), .rw_n (rw_n), .busy (busy),
      .exp_bus (exp_bus)
   );

   typedef struct {
      logic [3:0]  ce;
      logic [3:0]  pe;
      logic [14:0] ba;
      int          win;
      bit          wr;
      bit          ex;
      string       tag;
   } item_t;

   item_t sbq[$];
   item_t cur;
   bit    trk = 1'b0;
   int    s   = 0;
   int    n_chk  = 0;
   int    n_fail = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // expected result from the requirements, using the current configuration
   function automatic item_t model(input logic [1:0] kind, input logic [15:0] addr,
                                   input string tag);
      item_t it;
      int    phys;
      int    blk;
      bit    dat;
      dat    = (kind != 2'b00);
      phys   = (dat ? 65536 : 0) + int'(addr);
      it.ce  = 4'hF;
      it.pe  = 4'hF;
      it.ba  = '0;
      it.ex  = 1'b0;
      it.tag = tag;
      it.win = (kind == 2'b10) ? 8 : 4;
      it.wr  = 1'b0;
      if (periph_sel && dat) begin
         it.pe = ~(4'b0001 << (int'(addr) / 16384));
         it.ba = 15'(int'(addr) % 16384);
         it.wr = (kind == 2'b10);
      end else begin
         it.ba = 15'(phys % 32768);
         it.wr = (kind == 2'b10) && ((phys / 4096) >= int'(prog_bound));
         if (size_32k) begin
            blk = phys / 32768;
            if (blk > int'(rng_blk)) begin
               it.ex  = 1'b1;
               it.win = 0;
               it.wr  = 1'b0;
            end else begin
               it.ce = ~(4'b0001 << blk);
            end
         end else begin
            it.ce[0] = 1'b0;
            it.ce[1] = 1'((phys / 65536) % 2);
            it.ce[2] = 1'((phys / 32768) % 2);
            it.ce[3] = 1'b1;
         end
      end
      if (batt) begin
         it.ce = 4'hF;
         it.pe = it.pe | 4'b0011;
      end
      return it;
   endfunction

   // monitor: samples a quarter period after each rising edge
   always begin
      @(posedge clk);
      #(CLK_PER/4);
      if (!trk && sbq.size() > 0) begin
         cur = sbq.pop_front();
         trk = 1'b1;
         s   = 0;
      end
      if (trk) begin
         if (cur.ex) begin
            if (s == 0) begin
               chk(exp_bus === 1'b1, cur.tag, "exp_bus pulse", int'(exp_bus), 1);
               chk(busy === 1'b0, cur.tag, "busy on out-of-range", int'(busy), 0);
               chk(ce_n === 4'hF, cur.tag, "ce_n on out-of-range", int'(ce_n), 15);
            end else begin
               chk(exp_bus === 1'b0, cur.tag, "exp_bus one cycle", int'(exp_bus), 0);
               trk = 1'b0;
            end
         end else if (s < cur.win) begin
            chk(busy === 1'b1, cur.tag, "busy in window", int'(busy), 1);
            chk(ce_n === cur.ce, cur.tag, "ce_n", int'(ce_n), int'(cur.ce));
            chk(pe_n === cur.pe, cur.tag, "pe_n", int'(pe_n), int'(cur.pe));
            chk(ba === cur.ba, cur.tag, "ba", int'(ba), int'(cur.ba));
            chk(rw_n === !(cur.wr && s >= 1 && s <= 6), cur.tag, "rw_n (R7 timing)",
                int'(rw_n), int'(!(cur.wr && s >= 1 && s <= 6)));
         end else begin
            chk(busy === 1'b0 && ce_n === 4'hF && pe_n === 4'hF && rw_n === 1'b1,
                cur.tag, "idle after window (R7)", int'({busy, ce_n, pe_n, rw_n}), 'h1ff);
            trk = 1'b0;
         end
         s++;
      end
   end

   task automatic access(input logic [1:0] kind, input logic [15:0] addr,
                         input string tag);
      @(negedge clk);
      req_kind  = kind;
      req_addr  = addr;
      req_valid = 1'b1;
      sbq.push_back(model(kind, addr, tag));
      @(negedge clk);
      req_valid = 1'b0;
      wait (sbq.size() == 0 && !trk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PER * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_addr = '0;
      size_32k = 1'b1; periph_sel = 1'b0; rng_blk = 2'd3; prog_bound = 5'd0;
      pfail = 1'b0; batt = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ce_n === 4'hF && pe_n === 4'hF && rw_n === 1'b1, "R1", "outputs after reset",
          int'({ce_n, pe_n, rw_n}), 'h1ff);
      chk(busy === 1'b0 && exp_bus === 1'b0, "R1", "busy/exp after reset",
          int'({busy, exp_bus}), 0);

      // R2 32K mode, all four blocks, R7 read window
      access(2'b00, 16'h0000, "R2");
      access(2'b00, 16'h8123, "R2");
      access(2'b01, 16'h0005, "R2");
      access(2'b11, 16'h7FFF, "R2");
      access(2'b10, 16'hFFFF, "R7");

      // R4 range edges
      rng_blk = 2'd0;
      access(2'b00, 16'h7FFF, "R4");
      access(2'b00, 16'h8000, "R4");
      rng_blk = 2'd1;
      access(2'b01, 16'h0010, "R4");
      rng_blk = 2'd3;

      // R6 program boundary at 11000h
      prog_bound = 5'd17;
      access(2'b10, 16'h0FFF, "R6");
      access(2'b10, 16'h1000, "R6");

      // R3 128K mode
      size_32k = 1'b0; prog_bound = 5'd0; rng_blk = 2'd0;
      access(2'b00, 16'hC000, "R3");
      access(2'b10, 16'h4321, "R3");
      access(2'b01, 16'hFFFF, "R3");
      size_32k = 1'b1; rng_blk = 2'd3;

      // R5 peripheral windows, R11 single enable
      periph_sel = 1'b1; prog_bound = 5'd31;
      access(2'b01, 16'h3FFF, "R5");
      access(2'b01, 16'h4000, "R11");
      access(2'b01, 16'hBFFF, "R5");
      access(2'b10, 16'hC001, "R5");
      access(2'b00, 16'h9000, "R5");
      prog_bound = 5'd0;

      // R10 battery mode
      batt = 1'b1;
      access(2'b01, 16'hC000, "R10");
      access(2'b01, 16'h0000, "R10");
      periph_sel = 1'b0;
      access(2'b00, 16'h1234, "R10");
      batt = 1'b0;

      // R8 request during a busy window is ignored
      @(negedge clk);
      req_kind = 2'b10; req_addr = 16'h2222; req_valid = 1'b1;
      sbq.push_back(model(2'b10, 16'h2222, "R8"));
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      req_kind = 2'b00; req_addr = 16'h8000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait (sbq.size() == 0 && !trk);
      @(negedge clk);
      chk(busy === 1'b0 && ce_n === 4'hF, "R8", "no access started by ignored request",
          int'({busy, ce_n}), 'hf);

      // R9 power fail in the middle of a write
      @(negedge clk);
      req_kind = 2'b10; req_addr = 16'h0100; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(rw_n === 1'b0 && busy === 1'b1, "R9", "write strobe before power fail",
          int'({rw_n, busy}), 1);
      pfail = 1'b1;
      #1;
      chk(ce_n === 4'hF && pe_n === 4'hF && rw_n === 1'b1, "R9", "outputs forced by pfail",
          int'({ce_n, pe_n, rw_n}), 'h1ff);
      @(posedge clk);
      #(CLK_PER/4);
      chk(busy === 1'b0, "R9", "access dropped", int'(busy), 0);
      @(negedge clk);
      pfail = 1'b0;
      #1;
      chk(busy === 1'b0 && ce_n === 4'hF && rw_n === 1'b1, "R9", "stays idle after pfail",
          int'({busy, ce_n, rw_n}), 'h1f);
      @(negedge clk);
      pfail = 1'b1; req_kind = 2'b00; req_addr = 16'h0000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; pfail = 1'b0;
      #1;
      chk(busy === 1'b0 && ce_n === 4'hF && exp_bus === 1'b0, "R9",
          "request during pfail ignored", int'({busy, ce_n, exp_bus}), 'h1e);

      repeat (3) @(negedge clk);
      summary();
   end

endmodule